// File: doc/BRIEF.md
# Compare-Match Interval Timer

This block is a memory-mapped interval timer with a configurable number of channels. Each channel counts prescaled ticks of a separate slow counting clock, compares its count against a programmable limit, and on equality wraps back to zero. The wrap raises a sticky match flag, and the flag can drive a per-channel interrupt. A single shared start register holds one run bit per channel. A parameter selects a 16-bit or a 32-bit variant. The variant sets the counter width, the register spacing, the flag position and the prescale ratio.

The register bus runs on the bus clock and the counters run on the slow clock. Crossings between the two take three forms. A counter write uses a request/acknowledge handshake, driven by a small state machine with the states CW_IDLE, CW_SEND and CW_DRAIN. The machine goes from CW_IDLE to CW_SEND on a counter write, from CW_SEND to CW_DRAIN when the slow-side acknowledge arrives, and from CW_DRAIN back to CW_IDLE when the acknowledge drops. Counter reads return a snapshot that the slow domain passes back through a toggle handshake. Match events cross back to the bus clock as a toggle.

Top module: `cmt_top`

## Requirements
- R1: After reset the shared start register reads 0, each control/status register reads 0, each counter reads 0 and each compare register reads all ones.
- R2: The shared start register is at byte address 0, and bit n is the run bit of channel n. Channel n occupies the window starting at CH_BASE + n*CH_SPAN (defaults 16 and 16). Inside a channel, control/status is register index 0, the counter is index 1 and the compare register is index 2. The byte offset of a register is its index shifted left by 2 in the 32-bit variant and by 1 in the 16-bit variant.
- R3: While its run bit is set, a channel's counter advances by one every DIV slow-clock cycles. DIV is 8 in the 32-bit variant and 512 in the 16-bit variant. While the run bit is clear, the counter holds its value.
- R4: On a tick where the counter equals the compare value, the counter returns to 0, so one period is compare+1 ticks. The same event sets the match flag: bit 15 of control/status in the 32-bit variant, bit 7 in the 16-bit variant.
- R5: A control/status write with 0 in a flag bit clears that flag. Writing 1 to a flag bit leaves the flag unchanged.
- R6: In the 32-bit variant, bit 14 of control/status is an overrun flag. It is set when a match occurs while bit 15 is still set, and it is cleared by writing 0 to it.
- R7: Bit 6 of control/status is the interrupt enable. The channel interrupt output equals match flag AND enable, so writing 0 to control/status silences the interrupt.
- R8: A counter write reaches the counting logic only through a two-flop synchronizer in the slow domain, so a read issued one bus cycle later still returns the previous count. After the handshake completes, reads return the written value.
- R9: A counter write that arrives while an earlier one is still crossing (state not CW_IDLE) is dropped.
- R10: Channels are independent: the run bit of one channel does not move another channel's counter.
- R11: In the 32-bit variant the counter and compare registers are read and written as full 32-bit values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| slow_clk | input | 1 | Slow counting clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq | output | NUM_CH | Per-channel interrupt |

## Verification
On every cycle, the assertions check the following: the counter holds while its run bit is clear, the counter wraps to zero on a compare tick, a counter load takes the handshake data, the match flag rises only after a synchronized match event, flags survive writes of 1, the overrun flag rises only with the match flag, a zero control write silences the interrupt, and the held write data does not move while a crossing is busy. Other properties only the bench scenarios can show, because they depend on the relative rates of the two clocks and on end-to-end latency: the tick rate, the measured period of compare+1 ticks, the delayed visibility of a counter write, the address map and the independence of the channels.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
    typedef enum logic [1:0] {
        CW_IDLE  = 2'd0,
        CW_SEND  = 2'd1,
        CW_DRAIN = 2'd2
    } cw_state_e;

    localparam int REG_CSR = 0;
    localparam int REG_CNT = 1;
    localparam int REG_CMP = 2;
endpackage

// File: rtl/cmt_sync.sv
module cmt_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
    parameter int CW  = 32,
    parameter int DIV = 8
) (
    input  logic          sclk,
    input  logic          rst_n,
    input  logic          run_a,
    input  logic [CW-1:0] cmp_a,
    input  logic          ld_req_a,
    input  logic [CW-1:0] ld_data,
    output logic          ld_ack,
    input  logic          snap_ack_a,
    output logic          snap_tog,
    output logic [CW-1:0] snap,
    output logic          match_tog
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    logic          run_s, req_s, req_q, sack_s, load_now, tick;
    logic [CW-1:0] cmp_s1, cmp_s2, cmp_use, cnt;
    logic [PW-1:0] presc;

    cmt_sync #(.W(1)) u_run  (.clk(sclk), .rst_n(rst_n), .d(run_a),      .q(run_s));
    cmt_sync #(.W(1)) u_req  (.clk(sclk), .rst_n(rst_n), .d(ld_req_a),   .q(req_s));
    cmt_sync #(.W(1)) u_sack (.clk(sclk), .rst_n(rst_n), .d(snap_ack_a), .q(sack_s));

    assign load_now = req_s & ~req_q;
    assign ld_ack   = req_s;
    assign tick     = run_s && (presc == PW'(DIV - 1));

    // compare value is quasi-static: adopt it only once two samples agree
    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_s1  <= '1;
            cmp_s2  <= '1;
            cmp_use <= '1;
            req_q   <= 1'b0;
        end else begin
            cmp_s1 <= cmp_a;
            cmp_s2 <= cmp_s1;
            if (cmp_s1 == cmp_s2) cmp_use <= cmp_s2;
            req_q <= req_s;
        end
    end

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            presc     <= '0;
            match_tog <= 1'b0;
        end else if (load_now) begin
            cnt   <= ld_data;
            presc <= '0;
        end else if (run_s) begin
            presc <= tick ? '0 : presc + 1'b1;
            if (tick) begin
                if (cnt == cmp_use) begin
                    cnt       <= '0;
                    match_tog <= ~match_tog;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // snapshot loop: capture only after the bus side has taken the last one
    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            snap     <= '0;
            snap_tog <= 1'b0;
        end else if (sack_s == snap_tog) begin
            snap     <= cnt;
            snap_tog <= ~snap_tog;
        end
    end

    a_r3_hold_when_stopped: assert property (@(posedge sclk) disable iff (!rst_n)
        (!run_s && !load_now) |=> $stable(cnt));
    a_r4_wrap_to_zero: assert property (@(posedge sclk) disable iff (!rst_n)
        (tick && !load_now && cnt == cmp_use) |=> (cnt == '0));
    a_r8_load_takes_data: assert property (@(posedge sclk) disable iff (!rst_n)
        load_now |=> (cnt == $past(ld_data)));
endmodule

// File: rtl/cmt_chan.sv
module cmt_chan
    import cmt_pkg::*;
#(
    parameter int CW   = 32,
    parameter int DIV  = 8,
    parameter bit WIDE = 1'b1
) (
    input  logic          clk,
    input  logic          sclk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          wr_csr,
    input  logic          wr_cnt,
    input  logic          wr_cmp,
    input  logic [CW-1:0] wdata,
    output logic [31:0]   csr_rd,
    output logic [CW-1:0] cnt_rd,
    output logic [CW-1:0] cmp_rd,
    output logic          irq
);
    localparam int FLAG_BIT = WIDE ? 15 : 7;
    localparam int OVR_BIT  = 14;
    localparam int IE_BIT   = 6;

    cw_state_e     cw_q, cw_d;
    logic          req_q, ack_b, ld_ack, snap_tog, snt_b, sack_q;
    logic          match_tog, mt_b, mt_q, hit;
    logic          ie_q, flag_q, ovr_q;
    logic [CW-1:0] ld_data_q, snap, cmp_q;

    cmt_sync #(.W(1)) u_ack (.clk(clk), .rst_n(rst_n), .d(ld_ack),    .q(ack_b));
    cmt_sync #(.W(1)) u_snt (.clk(clk), .rst_n(rst_n), .d(snap_tog),  .q(snt_b));
    cmt_sync #(.W(1)) u_mt  (.clk(clk), .rst_n(rst_n), .d(match_tog), .q(mt_b));

    cmt_counter #(.CW(CW), .DIV(DIV)) u_cnt (
        .sclk(sclk), .rst_n(rst_n), .run_a(run), .cmp_a(cmp_q),
        .ld_req_a(req_q), .ld_data(ld_data_q), .ld_ack(ld_ack),
        .snap_ack_a(sack_q), .snap_tog(snap_tog), .snap(snap),
        .match_tog(match_tog)
    );

    // counter-write handshake: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cw_q <= CW_IDLE;
        else        cw_q <= cw_d;
    end

    always_comb begin
        cw_d = cw_q;
        unique case (cw_q)
            CW_IDLE:  if (wr_cnt) cw_d = CW_SEND;
            CW_SEND:  if (ack_b)  cw_d = CW_DRAIN;
            CW_DRAIN: if (!ack_b) cw_d = CW_IDLE;
            default:  cw_d = CW_IDLE;
        endcase
    end

    // counter-write handshake: registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q     <= 1'b0;
            ld_data_q <= '0;
        end else begin
            req_q <= (cw_d == CW_SEND);
            if (cw_q == CW_IDLE && wr_cnt) ld_data_q <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_rd <= '0;
            sack_q <= 1'b0;
            mt_q   <= 1'b0;
            cmp_q  <= '1;
        end else begin
            if (snt_b != sack_q) begin
                cnt_rd <= snap;
                sack_q <= snt_b;
            end
            mt_q <= mt_b;
            if (wr_cmp) cmp_q <= wdata;
        end
    end

    assign hit = mt_b ^ mt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q   <= 1'b0;
            flag_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (wr_csr) begin
                ie_q <= wdata[IE_BIT];
                if (!wdata[FLAG_BIT]) flag_q <= 1'b0;
                if (WIDE && !wdata[OVR_BIT]) ovr_q <= 1'b0;
            end
            if (hit) begin
                flag_q <= 1'b1;
                if (WIDE && flag_q) ovr_q <= 1'b1;
            end
        end
    end

    always_comb begin
        csr_rd           = '0;
        csr_rd[IE_BIT]   = ie_q;
        csr_rd[FLAG_BIT] = flag_q;
        if (WIDE) csr_rd[OVR_BIT] = ovr_q;
    end

    assign cmp_rd = cmp_q;
    assign irq    = flag_q & ie_q;

    a_r4_flag_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(hit));
    a_r5_one_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && wr_csr && wdata[FLAG_BIT]) |=> flag_q);
    a_r6_ovr_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_q) |-> flag_q);
    a_r7_zero_silences: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_csr && wdata == '0) |=> !irq);
    a_r9_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_q != CW_IDLE) |=> $stable(ld_data_q));
endmodule

// File: rtl/cmt_top.sv
module cmt_top
    import cmt_pkg::*;
#(
    parameter int NUM_CH  = 2,
    parameter bit WIDE    = 1'b1,
    parameter int AW      = 8,
    parameter int CH_BASE = 16,
    parameter int CH_SPAN = 16
) (
    input  logic              clk,
    input  logic              slow_clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    localparam int CW  = WIDE ? 32 : 16;
    localparam int DIV = WIDE ? 8 : 512;
    localparam int SH  = WIDE ? 2 : 1;

    function automatic logic [AW-1:0] reg_addr(input int ch, input int idx);
        return AW'(CH_BASE + ch * CH_SPAN + (idx << SH));
    endfunction

    logic [NUM_CH-1:0] start_q;
    logic [31:0]       csr_rd [NUM_CH];
    logic [CW-1:0]     cnt_rd [NUM_CH];
    logic [CW-1:0]     cmp_rd [NUM_CH];
    logic              wr;

    assign wr = bus_sel & bus_we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    start_q <= '0;
        else if (wr && bus_addr == '0) start_q <= bus_wdata[NUM_CH-1:0];
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam logic [AW-1:0] A_CSR = reg_addr(g, REG_CSR);
        localparam logic [AW-1:0] A_CNT = reg_addr(g, REG_CNT);
        localparam logic [AW-1:0] A_CMP = reg_addr(g, REG_CMP);

        cmt_chan #(.CW(CW), .DIV(DIV), .WIDE(WIDE)) u_chan (
            .clk(clk), .sclk(slow_clk), .rst_n(rst_n), .run(start_q[g]),
            .wr_csr(wr && bus_addr == A_CSR),
            .wr_cnt(wr && bus_addr == A_CNT),
            .wr_cmp(wr && bus_addr == A_CMP),
            .wdata(bus_wdata[CW-1:0]),
            .csr_rd(csr_rd[g]), .cnt_rd(cnt_rd[g]), .cmp_rd(cmp_rd[g]),
            .irq(irq[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            if (bus_addr == '0) bus_rdata = 32'(start_q);
            for (int i = 0; i < NUM_CH; i++) begin
                if (bus_addr == reg_addr(i, REG_CSR)) bus_rdata = csr_rd[i];
                if (bus_addr == reg_addr(i, REG_CNT)) bus_rdata = 32'(cnt_rd[i]);
                if (bus_addr == reg_addr(i, REG_CMP)) bus_rdata = 32'(cmp_rd[i]);
            end
        end
    end
endmodule

// File: tb/cmt_top_test.sv
module cmt_top_test;
    localparam int CLK_PERIOD  = 10;
    localparam int SLOW_PERIOD = 34;
    localparam logic [7:0] A_START = 8'd0;
    localparam logic [7:0] A_CSR0 = 8'd16, A_CNT0 = 8'd20, A_CMP0 = 8'd24;
    localparam logic [7:0] A_CSR1 = 8'd32, A_CNT1 = 8'd36, A_CMP1 = 8'd40;

    logic        clk = 0, slow_clk = 0, rst_n = 0;
    logic        bus_sel = 0, bus_we = 0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [1:0]  irq;

    int errors = 0, checks = 0, cyc = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] exp;
        logic [31:0] mask;
        string       tag;
    } item_t;
    item_t sb_q[$];
    bit    rd_pend = 0;

    cmt_top #(.NUM_CH(2), .WIDE(1'b1)) uut (
        .clk(clk), .slow_clk(slow_clk), .rst_n(rst_n), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    initial forever #(CLK_PERIOD / 2) clk = ~clk;
    initial forever #(SLOW_PERIOD / 2) slow_clk = ~slow_clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected items and compares away from the active edge
    initial forever begin
        @(negedge clk);
        if (rd_pend && sb_q.size() > 0) begin
            item_t it = sb_q.pop_front();
            chk((bus_rdata & it.mask) == (it.exp & it.mask), it.tag,
                bus_rdata & it.mask, it.exp & it.mask);
            rd_pend = 0;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] e,
                             input logic [31:0] m, input string tag);
        item_t it;
        @(posedge clk); #1;
        bus_sel = 1; bus_we = 0; bus_addr = a;
        it.exp = e; it.mask = m; it.tag = tag;
        sb_q.push_back(it);
        rd_pend = 1;
        wait (!rd_pend);
        bus_sel = 0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] v);
        @(posedge clk); #1;
        bus_sel = 1; bus_we = 0; bus_addr = a;
        @(negedge clk);
        v = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic wait_flag0(output bit seen);
        logic [31:0] v;
        seen = 0;
        for (int k = 0; k < 3000 && !seen; k++) begin
            peek(A_CSR0, v);
            seen = v[15];
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] a, b, v;
        bit seen;
        int t0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (5) @(posedge clk);

        // R1 reset state
        expect_rd(A_START, 32'h0, '1, "R1 start reg");
        expect_rd(A_CSR0, 32'h0, '1, "R1 csr0");
        expect_rd(A_CNT0, 32'h0, '1, "R1 cnt0");
        expect_rd(A_CMP0, 32'hFFFF_FFFF, '1, "R1 cmp0");
        expect_rd(A_CMP1, 32'hFFFF_FFFF, '1, "R1 cmp1");

        // R11 full-width compare access
        wr(A_CMP0, 32'hA5A5_1234);
        expect_rd(A_CMP0, 32'hA5A5_1234, '1, "R11 cmp 32-bit");
        wr(A_CMP0, 32'hFFFF_FFFF);

        // R3 stopped counter holds
        repeat (200) @(posedge clk);
        expect_rd(A_CNT0, 32'h0, '1, "R3 no count while stopped");

        // R3 rate, R10 independence
        wr(A_START, 32'h1);
        repeat (50) @(posedge clk);
        peek(A_CNT0, a);
        repeat (2720) @(posedge clk);
        peek(A_CNT0, b);
        chk((b - a) >= 98 && (b - a) <= 102, "R3 tick rate", b - a, 32'd100);
        expect_rd(A_CNT1, 32'h0, '1, "R10 other channel idle");
        wr(A_START, 32'h0);
        repeat (100) @(posedge clk);
        peek(A_CNT0, a);
        repeat (300) @(posedge clk);
        expect_rd(A_CNT0, a, '1, "R3 hold after stop");

        // R8 delayed write visibility
        wr(A_CNT0, 32'h40);
        expect_rd(A_CNT0, a, '1, "R8 old value right after write");
        repeat (100) @(posedge clk);
        expect_rd(A_CNT0, 32'h40, '1, "R8 written value visible");

        // R9 write during crossing dropped
        wr(A_CNT0, 32'h100);
        wr(A_CNT0, 32'h200);
        repeat (150) @(posedge clk);
        expect_rd(A_CNT0, 32'h100, '1, "R9 second write dropped");

        // R4 wrap and period
        wr(A_CMP0, 32'd3);
        wr(A_CNT0, 32'd0);
        wr(A_CSR0, 32'h40);
        repeat (100) @(posedge clk);
        wr(A_START, 32'h1);
        wait_flag0(seen);
        chk(seen, "R4 flag after match", 32'(seen), 32'd1);
        wr(A_CSR0, 32'hC040);
        expect_rd(A_CSR0, 32'h8000, 32'h8000, "R5 write of 1 keeps flag");
        @(negedge clk);
        chk(irq[0] == 1'b1, "R7 irq with flag and enable", 32'(irq[0]), 32'd1);
        wr(A_CSR0, 32'h0040);
        t0 = cyc;
        expect_rd(A_CSR0, 32'h0040, '1, "R5 write of 0 clears flag");
        peek(A_CNT0, v);
        chk(v <= 32'd3, "R4 count never above compare", v, 32'd3);
        wait_flag0(seen);
        chk((cyc - t0) >= 95 && (cyc - t0) <= 125, "R4 period compare+1 ticks",
            32'(cyc - t0), 32'd109);

        // R6 overrun
        repeat (300) @(posedge clk);
        expect_rd(A_CSR0, 32'hC040, '1, "R6 overrun flag set");
        wr(A_CSR0, 32'h0040);
        expect_rd(A_CSR0, 32'h0040, '1, "R6 overrun cleared");

        // R7 zero write disables interrupt
        wr(A_CSR0, 32'h0);
        @(negedge clk);
        chk(irq[0] == 1'b0, "R7 irq off after zero write", 32'(irq[0]), 32'd0);
        repeat (150) @(posedge clk);
        peek(A_CSR0, v);
        @(negedge clk);
        chk(v[15] == 1'b1 && irq[0] == 1'b0, "R7 flag without irq",
            {v[15], 30'd0, irq[0]}, 32'h8000_0000);
        wr(A_START, 32'h0);

        // R2 address map for channel 1
        wr(A_CMP1, 32'h1234_5678);
        expect_rd(A_CMP1, 32'h1234_5678, '1, "R2 ch1 compare address");
        expect_rd(A_CMP0, 32'd3, '1, "R2 ch0 compare untouched");
        expect_rd(A_CSR1, 32'h0, '1, "R2 ch1 csr address");
        wr(A_START, 32'h2);
        expect_rd(A_START, 32'h2, '1, "R2 start bit per channel");
        wr(A_START, 32'h0);

        finish_run();
    end
endmodule